// File: doc/BRIEF.md
# Zero-Sequence Injection PWM Modulator

This block sits between a field-oriented current controller and the PWM carrier of a three-leg inverter. Each sample carries three signed phase voltage references. The block shifts all three by one common-mode offset and turns them into unsigned duty words. A small mode state machine picks the offset rule:

- **Centred space-vector injection** keeps all three legs switching.
- **Clamp-low** pins the smallest phase to the bottom rail.
- **Clamp-high** pins the largest phase to the top rail.

The two clamping modes cut the number of commutations on one leg for long stretches of the electrical cycle. After the offset, each duty is saturated. Duties that come closer to a rail than a programmable minimum pulse width are snapped fully onto that rail. A per-leg flag marks every leg whose final duty sits on a rail.

The mode state machine has three states: `ST_SVM`, `ST_CLMIN` and `ST_CLMAX`. It leaves its state only on the carrier-period strobe `period_start`, and it does so through one of three transitions:

- `mode_sel` = 1 goes to `ST_CLMIN`.
- `mode_sel` = 2 goes to `ST_CLMAX`.
- `mode_sel` = 0 or 3 goes to `ST_SVM`.

Without the strobe, every state loops back to itself. The data path is a three-register pipeline:

- capture;
- extrema search plus offset;
- duty shaping.

Top module: `zsi_modulator`

## Requirements
- R1: During and after reset, before any input sample, `out_valid` is 0, every duty reads 32768 (mid-scale), `clamped` is 0, and the active mode is space-vector.
- R2: In space-vector mode, the offset is floor((min+max)/2) of the three references. Each duty is ref − offset + 32768.
- R3: In clamp-low mode (`mode_sel` code 1), the offset is min + 32768. The smallest phase therefore gets duty 0, and every phase gets ref − offset + 32768.
- R4: In clamp-high mode (`mode_sel` code 2), the offset is max − 32767. The largest phase therefore gets duty 65535, and every phase gets ref − offset + 32768.
- R5: With threshold T on `min_pulse`, the duty is shaped after saturation. A duty d < T becomes 0. Otherwise, a duty with 65535 − d < T becomes 65535. T = 0 disables suppression.
- R6: `mode_sel` takes effect only in a cycle where `period_start` is 1, and it applies to a sample captured in that same cycle. `mode_sel` changes without the strobe are ignored. Code 0 and code 3 both select space-vector mode.
- R7: A sample with `in_valid` high at a rising edge produces `out_valid` high, together with its duties, after the third rising edge counted from that edge. Samples may arrive every cycle.
- R8: Before suppression, the shifted duty is saturated to the range [0, 65535].
- R9: `clamped[i]` is 1 exactly when the final duty of leg i (bit 0 = a, bit 1 = b, bit 2 = c) is 0 or 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks a sample of the three references |
| period_start | input | 1 | Carrier period boundary strobe; mode may change here |
| mode_sel | input | 2 | Offset rule: 0/3 space-vector, 1 clamp-low, 2 clamp-high |
| min_pulse | input | 16 | Short-pulse threshold in duty counts |
| ref_a | input | 16 | Signed reference of leg a |
| ref_b | input | 16 | Signed reference of leg b |
| ref_c | input | 16 | Signed reference of leg c |
| out_valid | output | 1 | Marks valid duty words |
| duty_a | output | 16 | Unsigned duty of leg a |
| duty_b | output | 16 | Unsigned duty of leg b |
| duty_c | output | 16 | Unsigned duty of leg c |
| clamped | output | 3 | Per-leg rail flag |

## Verification
The assertions check the following on every cycle:

- the three-cycle valid latency;
- that the mode state holds between period strobes;
- that in clamp-low mode some leg sits at 0, and in clamp-high mode some leg sits at full scale;
- that no emitted duty lies strictly inside the suppressed band next to a rail.

The exact duty values need the bench's scenarios. These include the rounding of the centred offset for odd sums and the saturation of extreme references. They also cover ties among phases, an ignored mode change without a strobe, code 3, and back-to-back samples across mode switches.

// File: rtl/zsi_pkg.sv
package zsi_pkg;

    typedef enum logic [1:0] {
        ST_SVM   = 2'd0,
        ST_CLMIN = 2'd1,
        ST_CLMAX = 2'd2
    } zsi_state_e;

    localparam logic [1:0] SEL_SVM   = 2'd0;
    localparam logic [1:0] SEL_CLMIN = 2'd1;
    localparam logic [1:0] SEL_CLMAX = 2'd2;
    localparam logic [1:0] SEL_ALT   = 2'd3;

endpackage

// File: rtl/zsi_mode_fsm.sv
module zsi_mode_fsm
    import zsi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       period_start,
    input  logic [1:0] mode_sel,
    output zsi_state_e eff_mode
);

    zsi_state_e state_q;
    zsi_state_e state_nxt;

    // next-state: transitions only on the carrier-period strobe
    always_comb begin
        state_nxt = state_q;
        if (period_start) begin
            unique case (mode_sel)
                SEL_CLMIN: state_nxt = ST_CLMIN;
                SEL_CLMAX: state_nxt = ST_CLMAX;
                SEL_SVM:   state_nxt = ST_SVM;
                SEL_ALT:   state_nxt = ST_SVM;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SVM;
        else        state_q <= state_nxt;
    end

    // output: a sample taken on the strobe cycle already uses the new rule
    always_comb begin
        eff_mode = state_nxt;
    end

    // R6: no state change between period strobes
    a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> $stable(state_q));

endmodule

// File: rtl/zsi_extrema.sv
module zsi_extrema #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] v0,
    input  logic signed [W-1:0] v1,
    input  logic signed [W-1:0] v2,
    output logic signed [W-1:0] vmin,
    output logic signed [W-1:0] vmax
);

    logic signed [W-1:0] lo01;
    logic signed [W-1:0] hi01;

    // first comparator stage: legs 0 and 1, ties keep the lower index
    always_comb begin
        lo01 = (v1 < v0) ? v1 : v0;
        hi01 = (v1 > v0) ? v1 : v0;
    end

    // second comparator stage: fold in leg 2
    always_comb begin
        vmin = (v2 < lo01) ? v2 : lo01;
        vmax = (v2 > hi01) ? v2 : hi01;
    end

endmodule

// File: rtl/zsi_duty_shaper.sv
module zsi_duty_shaper #(
    parameter int W = 16
) (
    input  logic signed [W+1:0] shifted,
    input  logic [W-1:0]        thr,
    output logic [W-1:0]        duty,
    output logic                on_rail
);

    localparam int EW = W + 2;
    localparam logic signed [EW-1:0] HALF_E = {2'b00, 1'b1, {(W-1){1'b0}}};
    localparam logic signed [EW-1:0] FULL_E = {2'b00, {W{1'b1}}};
    localparam logic [W-1:0]         FULL_W = {W{1'b1}};

    logic signed [EW-1:0] biased;
    logic [W-1:0]         sat;
    logic [W-1:0]         gap_hi;

    always_comb begin
        biased = shifted + HALF_E;
        if (biased < 0)            sat = '0;
        else if (biased > FULL_E)  sat = FULL_W;
        else                       sat = biased[W-1:0];
    end

    always_comb begin
        gap_hi = FULL_W - sat;
        if (sat < thr)          duty = '0;
        else if (gap_hi < thr)  duty = FULL_W;
        else                    duty = sat;
        on_rail = (duty == '0) || (duty == FULL_W);
    end

endmodule

// File: rtl/zsi_modulator.sv
module zsi_modulator
    import zsi_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                period_start,
    input  logic [1:0]          mode_sel,
    input  logic [W-1:0]        min_pulse,
    input  logic signed [W-1:0] ref_a,
    input  logic signed [W-1:0] ref_b,
    input  logic signed [W-1:0] ref_c,
    output logic                out_valid,
    output logic [W-1:0]        duty_a,
    output logic [W-1:0]        duty_b,
    output logic [W-1:0]        duty_c,
    output logic [2:0]          clamped
);

    localparam int LEGS = 3;
    localparam int EW   = W + 2;
    localparam logic signed [EW-1:0] HALF_E   = {2'b00, 1'b1, {(W-1){1'b0}}};
    localparam logic signed [EW-1:0] HALFM1_E = {3'b000, {(W-1){1'b1}}};
    localparam logic [W-1:0]         FULL_W   = {W{1'b1}};
    localparam logic [W-1:0]         MID_W    = {1'b1, {(W-1){1'b0}}};

    // ---------------- stage 1: capture ----------------
    zsi_state_e          eff_mode;
    logic signed [W-1:0] v1_q [LEGS];
    logic [W-1:0]        thr1_q;
    zsi_state_e          mode1_q;
    logic                vld1_q;

    zsi_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .mode_sel     (mode_sel),
        .eff_mode     (eff_mode)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld1_q  <= 1'b0;
            thr1_q  <= '0;
            mode1_q <= ST_SVM;
            v1_q[0] <= '0;
            v1_q[1] <= '0;
            v1_q[2] <= '0;
        end else begin
            vld1_q <= in_valid;
            if (in_valid) begin
                thr1_q  <= min_pulse;
                mode1_q <= eff_mode;
                v1_q[0] <= ref_a;
                v1_q[1] <= ref_b;
                v1_q[2] <= ref_c;
            end
        end
    end

    // ---------------- stage 2: extrema and offset ----------------
    logic signed [W-1:0]  vmin;
    logic signed [W-1:0]  vmax;
    logic signed [EW-1:0] min_e;
    logic signed [EW-1:0] max_e;
    logic signed [EW-1:0] offset;
    logic signed [EW-1:0] sh_d  [LEGS];
    logic signed [EW-1:0] sh2_q [LEGS];
    logic [W-1:0]         thr2_q;
    zsi_state_e           mode2_q;
    logic                 vld2_q;

    zsi_extrema #(.W(W)) u_ext (
        .v0   (v1_q[0]),
        .v1   (v1_q[1]),
        .v2   (v1_q[2]),
        .vmin (vmin),
        .vmax (vmax)
    );

    always_comb begin
        min_e = {{2{vmin[W-1]}}, vmin};
        max_e = {{2{vmax[W-1]}}, vmax};
        unique case (mode1_q)
            ST_CLMIN: offset = min_e + HALF_E;
            ST_CLMAX: offset = max_e - HALFM1_E;
            default:  offset = (min_e + max_e) >>> 1;
        endcase
    end

    for (genvar g = 0; g < LEGS; g++) begin : g_shift
        always_comb sh_d[g] = {{2{v1_q[g][W-1]}}, v1_q[g]} - offset;

        always_ff @(posedge clk) begin
            if (!rst_n) sh2_q[g] <= '0;
            else if (vld1_q) sh2_q[g] <= sh_d[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld2_q  <= 1'b0;
            thr2_q  <= '0;
            mode2_q <= ST_SVM;
        end else begin
            vld2_q <= vld1_q;
            if (vld1_q) begin
                thr2_q  <= thr1_q;
                mode2_q <= mode1_q;
            end
        end
    end

    // ---------------- stage 3: saturation, suppression ----------------
    logic [W-1:0] duty_d [LEGS];
    logic [W-1:0] duty_q [LEGS];
    logic [LEGS-1:0] rail_d;
    logic [LEGS-1:0] rail_q;
    logic vld3_q;

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        zsi_duty_shaper #(.W(W)) u_shape (
            .shifted (sh2_q[g]),
            .thr     (thr2_q),
            .duty    (duty_d[g]),
            .on_rail (rail_d[g])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                duty_q[g] <= MID_W;
                rail_q[g] <= 1'b0;
            end else if (vld2_q) begin
                duty_q[g] <= duty_d[g];
                rail_q[g] <= rail_d[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld3_q <= 1'b0;
        else        vld3_q <= vld2_q;
    end

    assign out_valid = vld3_q;
    assign duty_a    = duty_q[0];
    assign duty_b    = duty_q[1];
    assign duty_c    = duty_q[2];
    assign clamped   = rail_q;

    // R7: fixed three-cycle latency
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    // R3: clamp-low leaves one leg on the bottom rail
    a_r3_low_rail: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode2_q) == ST_CLMIN) |->
        (duty_a == '0 || duty_b == '0 || duty_c == '0));

    // R4: clamp-high leaves one leg on the top rail
    a_r4_high_rail: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode2_q) == ST_CLMAX) |->
        (duty_a == FULL_W || duty_b == FULL_W || duty_c == FULL_W));

    // R5: no emitted duty inside the suppressed band
    a_r5_no_short_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |->
        ((duty_a == '0 || duty_a == FULL_W ||
          (duty_a >= $past(thr2_q) && (FULL_W - duty_a) >= $past(thr2_q))) &&
         (duty_b == '0 || duty_b == FULL_W ||
          (duty_b >= $past(thr2_q) && (FULL_W - duty_b) >= $past(thr2_q))) &&
         (duty_c == '0 || duty_c == FULL_W ||
          (duty_c >= $past(thr2_q) && (FULL_W - duty_c) >= $past(thr2_q)))));

endmodule

// File: tb/sim_zsi_modulator.sv
module sim_zsi_modulator;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic period_start = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic [15:0] min_pulse = 16'd0;
    logic signed [15:0] ref_a = '0;
    logic signed [15:0] ref_b = '0;
    logic signed [15:0] ref_c = '0;
    logic out_valid;
    logic [15:0] duty_a, duty_b, duty_c;
    logic [2:0] clamped;

    always #2.5 clk = ~clk;

    zsi_modulator u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .period_start(period_start), .mode_sel(mode_sel),
        .min_pulse(min_pulse), .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
        .out_valid(out_valid), .duty_a(duty_a), .duty_b(duty_b),
        .duty_c(duty_c), .clamped(clamped)
    );

    typedef struct {
        int d0; int d1; int d2;
        logic [2:0] fl;
        int cyc;
        string tag;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int bmode = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int shape(input int v, input int off, input int thr);
        int x;
        x = v - off + 32768;
        if (x < 0) x = 0;                  // R8 saturation
        if (x > 65535) x = 65535;
        if (x < thr) x = 0;                // R5 suppression
        else if (65535 - x < thr) x = 65535;
        return x;
    endfunction

    task automatic send(input int a, input int b, input int c, input int sel,
                        input bit st, input int thr, input string tag);
        exp_t e;
        int mn, mx, off;
        @(negedge clk);
        ref_a = 16'(a); ref_b = 16'(b); ref_c = 16'(c);
        mode_sel = 2'(sel); period_start = st; min_pulse = 16'(thr);
        in_valid = 1'b1;
        if (st) bmode = (sel == 1) ? 1 : (sel == 2) ? 2 : 0;   // R6
        mn = a; if (b < mn) mn = b; if (c < mn) mn = c;
        mx = a; if (b > mx) mx = b; if (c > mx) mx = c;
        if (bmode == 1)      off = mn + 32768;                 // R3
        else if (bmode == 2) off = mx - 32767;                 // R4
        else                 off = (mn + mx) >>> 1;            // R2
        e.d0 = shape(a, off, thr);
        e.d1 = shape(b, off, thr);
        e.d2 = shape(c, off, thr);
        e.fl = {(e.d2 == 0 || e.d2 == 65535), (e.d1 == 0 || e.d1 == 65535),
                (e.d0 == 0 || e.d0 == 65535)};
        e.cyc = cyc + 3;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            period_start = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                chk("R7 unexpected output", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({"R7 latency ", e.tag}, cyc, e.cyc);
                chk({e.tag, " duty_a"}, int'(duty_a), e.d0);
                chk({e.tag, " duty_b"}, int'(duty_b), e.d1);
                chk({e.tag, " duty_c"}, int'(duty_c), e.d2);
                chk({"R9 flags ", e.tag}, int'(clamped), int'(e.fl));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 out_valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 duty_a", int'(duty_a), 32768);
        chk("R1 duty_b", int'(duty_b), 32768);
        chk("R1 duty_c", int'(duty_c), 32768);
        chk("R1 clamped", int'(clamped), 0);

        // R1 default mode is space-vector, R2 offset
        send(1000, -2000, 500, 0, 0, 0, "R1 R2 default svm");
        idle(4);
        send(3, 0, -2, 0, 1, 0, "R2 odd sum floor");
        idle(4);
        send(100, 100, 100, 0, 0, 0, "R2 tie");
        idle(4);
        // R3 clamp-low
        send(1000, -2000, 500, 1, 1, 0, "R3 clamp low");
        idle(4);
        send(-700, -700, 900, 1, 0, 0, "R3 tie low");
        idle(4);
        // R4 clamp-high
        send(1000, -2000, 500, 2, 1, 0, "R4 clamp high");
        idle(4);
        // R6 ignored change without strobe
        send(1000, -2000, 500, 0, 0, 0, "R6 ignored sel");
        idle(4);
        // R6 code 3 selects space-vector
        send(1000, -2000, 500, 3, 1, 0, "R6 code3 svm");
        idle(4);
        // R5 suppression
        send(31000, -31000, 0, 0, 0, 4000, "R5 suppress");
        idle(4);
        send(20000, -20000, 5, 0, 0, 40000, "R5 big thr");
        idle(4);
        // R8 saturation
        send(32767, -32768, 0, 0, 0, 0, "R8 saturate");
        idle(4);
        send(32767, -32768, 0, 1, 1, 0, "R8 clamp low sat");
        idle(4);
        // R7 back-to-back with mode switches
        send(500, 200, -300, 2, 1, 0, "R7 b2b 1");
        send(-500, 200, 300, 1, 1, 0, "R7 b2b 2");
        send(50, 60, 70, 0, 0, 100, "R7 b2b 3");
        send(-8000, 9000, 0, 0, 1, 100, "R7 b2b 4");
        idle(5);
        // mixed sequence
        for (int i = 0; i < 300; i++) begin
            send(int'($urandom_range(65535)) - 32768,
                 int'($urandom_range(65535)) - 32768,
                 int'($urandom_range(65535)) - 32768,
                 int'($urandom_range(3)), ($urandom_range(3) == 0),
                 int'($urandom_range(3000)), "R2 R3 R4 R5 R6 mixed");
            if ($urandom_range(2) == 0) idle(1);
        end
        idle(6);
        chk("R7 drained", sb.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule